// File: doc/BRIEF.md
# Interrupt Aggregation Controller

This block gathers a parameterised set of interrupt request lines (at most 32) into a single interrupt pin for a processor. Every source line first crosses into the controller clock domain through a synchroniser. It is then qualified by its own trigger setting: edge or level, and a selected active sense. A qualified event records a pending bit. Pending bits pass through a per-source enable mask, and the surviving bits drive one output pin. That pin can present either a steady level or a single-cycle strobe, and either sense.

Software reaches seven 32-bit words over a plain write-strobe and address bus. Reads are combinational. The enable, pending, source-mode, source-sense and force words hold one bit per source. The output-style and output-sense words hold a single bit in bit 0. Pending bits are cleared by writing ones. Writing ones to the force word injects pending bits. Changing a source's trigger setting discards its pending bit, so a reconfiguration cannot leave a false event behind.

Top module: `intagg_ctrl`

## Requirements
- R1: While reset is held, every register reads 0 and `irq_o` reads 1, because output sense 0 means active low and the output is inactive.
- R2: Byte offsets are as follows. 0x00 is enable, 0x04 is pending, 0x08 is source mode, 0x0C is source sense, 0x10 is output style (bit 0), 0x14 is output sense (bit 0) and 0x18 is force. The force word always reads 0. Any other offset reads 0 and ignores writes.
- R3: A source with mode bit 1 is edge triggered. Sense 1 selects rising edges and sense 0 selects falling edges, and the other edge is ignored. The pending bit becomes readable on the third rising clock edge after the input changes, and not on the second.
- R4: A source with mode bit 0 is level triggered. Sense 1 selects high and sense 0 selects low. Its pending bit is set while the level is active and stays set after the level goes away, until software clears it.
- R5: Writing 1 to a pending bit clears it, and writing 0 leaves it alone. A clear is overridden while the source is still raising its event, so a level source whose input is still active stays pending.
- R6: Writing 1 to a bit of the force word sets that pending bit on the next clock edge.
- R7: A write to the mode word or the sense word clears the pending bit of each source whose bit changes. Pending bits of sources whose setting is unchanged are kept.
- R8: With output style 0, the output is active one clock edge after any pending bit is both set and enabled, and it is inactive one edge after none is.
- R9: With output style 1, the output is active for exactly one cycle each time a new bit appears in the enabled pending set.
- R10: Output sense 1 makes `irq_o` active high. Output sense 0 makes it active low. The sense takes effect on `irq_o` in the cycle after the write.
- R11: The start-up sequence is accepted: clear enable, output style and output sense, then write all ones to pending. After it, with no active source, pending reads 0 and the output is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr_i | input | ADDR_W | Byte address of the register word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| src_i | input | NUM_SRC | Asynchronous interrupt source lines |
| irq_o | output | 1 | Aggregated interrupt pin |

## Verification
The pending word is readable at any time. A wrong synchroniser depth, a wrong edge polarity or a dropped latch therefore shows up as a wrong pending bit within three or four cycles of a source change. The bench checks that exact cycle on directed cases and at a settled point in random rounds. A broken mask or output stage shows on `irq_o` one cycle after the pending state settles. Pulse mode is checked cycle by cycle, because a pulse that is stuck or missing only differs from a correct one in the cycles right after it.

// File: rtl/intagg_pkg.sv
package intagg_pkg;

   localparam int REG_W = 32;

   typedef enum logic [2:0] {
      SEL_EN    = 3'd0,
      SEL_PEND  = 3'd1,
      SEL_SMODE = 3'd2,
      SEL_SSENS = 3'd3,
      SEL_OSTY  = 3'd4,
      SEL_OSENS = 3'd5,
      SEL_FORCE = 3'd6,
      SEL_NONE  = 3'd7
   } reg_sel_e;

   // Map an aligned, in-range word index onto a register selector.
   function automatic reg_sel_e word_decode(input logic in_range, input logic [2:0] idx);
      reg_sel_e sel;
      if (!in_range) sel = SEL_NONE;
      else           sel = reg_sel_e'(idx);
      return sel;
   endfunction

endpackage

// File: rtl/intagg_sync.sv
module intagg_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   logic [STAGES-1:0][WIDTH-1:0] pipe_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[STAGES-2:0], async_i};
   end

   assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/intagg_detect.sv
module intagg_detect #(
   parameter int NUM_SRC = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] sync_i,
   input  logic [NUM_SRC-1:0] smode_i,
   input  logic [NUM_SRC-1:0] ssens_i,
   input  logic [NUM_SRC-1:0] w1c_i,
   input  logic [NUM_SRC-1:0] force_i,
   input  logic [NUM_SRC-1:0] cfg_clr_i,
   output logic [NUM_SRC-1:0] pend_o,
   output logic [NUM_SRC-1:0] lvl_act_o
);
   logic [NUM_SRC-1:0] prev_q;
   logic [NUM_SRC-1:0] pend_q;
   logic [NUM_SRC-1:0] pend_n;

   for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
      logic rise, fall, edge_hit, lvl_hit, set_b;
      assign rise     = sync_i[b] & ~prev_q[b];
      assign fall     = ~sync_i[b] & prev_q[b];
      assign edge_hit = ssens_i[b] ? rise : fall;
      assign lvl_hit  = ssens_i[b] ? sync_i[b] : ~sync_i[b];
      assign set_b    = (smode_i[b] ? edge_hit : lvl_hit) | force_i[b];
      // configuration change wins, then a new event, then a software clear
      assign pend_n[b] = cfg_clr_i[b] ? 1'b0 : (set_b | (pend_q[b] & ~w1c_i[b]));
      assign lvl_act_o[b] = lvl_hit;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= '0;
         pend_q <= '0;
      end else begin
         prev_q <= sync_i;
         pend_q <= pend_n;
      end
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/intagg_regs.sv
module intagg_regs
   import intagg_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int ADDR_W  = 5
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [REG_W-1:0]   wdata_i,
   input  logic [NUM_SRC-1:0] pend_i,
   output logic [REG_W-1:0]   rdata_o,
   output logic [NUM_SRC-1:0] enable_o,
   output logic [NUM_SRC-1:0] smode_o,
   output logic [NUM_SRC-1:0] ssens_o,
   output logic [NUM_SRC-1:0] w1c_o,
   output logic [NUM_SRC-1:0] force_o,
   output logic [NUM_SRC-1:0] cfg_clr_o,
   output logic               osty_o,
   output logic               osens_o
);
   logic               in_range;
   reg_sel_e           sel;
   logic [NUM_SRC-1:0] wbits;
   logic [NUM_SRC-1:0] en_q, smode_q, ssens_q;
   logic               osty_q, osens_q;
   logic               wr_en, wr_smode, wr_ssens;

   assign in_range = ((addr_i >> 5) == '0) && (addr_i[1:0] == 2'b00);
   assign sel      = word_decode(in_range, addr_i[4:2]);
   assign wbits    = wdata_i[NUM_SRC-1:0];

   assign wr_en    = wr_i && (sel == SEL_EN);
   assign wr_smode = wr_i && (sel == SEL_SMODE);
   assign wr_ssens = wr_i && (sel == SEL_SSENS);

   assign w1c_o     = (wr_i && sel == SEL_PEND)  ? wbits : '0;
   assign force_o   = (wr_i && sel == SEL_FORCE) ? wbits : '0;
   assign cfg_clr_o = (wr_smode ? (wbits ^ smode_q) : '0)
                    | (wr_ssens ? (wbits ^ ssens_q) : '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q    <= '0;
         smode_q <= '0;
         ssens_q <= '0;
         osty_q  <= 1'b0;
         osens_q <= 1'b0;
      end else begin
         if (wr_en)    en_q    <= wbits;
         if (wr_smode) smode_q <= wbits;
         if (wr_ssens) ssens_q <= wbits;
         if (wr_i && sel == SEL_OSTY)  osty_q  <= wdata_i[0];
         if (wr_i && sel == SEL_OSENS) osens_q <= wdata_i[0];
      end
   end

   always_comb begin
      rdata_o = '0;
      unique case (sel)
         SEL_EN:    rdata_o[NUM_SRC-1:0] = en_q;
         SEL_PEND:  rdata_o[NUM_SRC-1:0] = pend_i;
         SEL_SMODE: rdata_o[NUM_SRC-1:0] = smode_q;
         SEL_SSENS: rdata_o[NUM_SRC-1:0] = ssens_q;
         SEL_OSTY:  rdata_o[0]           = osty_q;
         SEL_OSENS: rdata_o[0]           = osens_q;
         SEL_FORCE: rdata_o              = '0;
         default:   rdata_o              = '0;
      endcase
   end

   assign enable_o = en_q;
   assign smode_o  = smode_q;
   assign ssens_o  = ssens_q;
   assign osty_o   = osty_q;
   assign osens_o  = osens_q;
endmodule

// File: rtl/intagg_outgen.sv
module intagg_outgen #(
   parameter int NUM_SRC = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] pend_i,
   input  logic [NUM_SRC-1:0] enable_i,
   input  logic               osty_i,
   input  logic               osens_i,
   output logic               irq_o
);
   logic [NUM_SRC-1:0] live, live_q;
   logic               act_q;

   assign live = pend_i & enable_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         live_q <= '0;
         act_q  <= 1'b0;
      end else begin
         live_q <= live;
         act_q  <= osty_i ? |(live & ~live_q) : |live;
      end
   end

   assign irq_o = osens_i ? act_q : ~act_q;
endmodule

// File: rtl/intagg_ctrl.sv
module intagg_ctrl
   import intagg_pkg::*;
#(
   parameter int NUM_SRC     = 32,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               bus_wr_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [REG_W-1:0]   bus_wdata_i,
   output logic [REG_W-1:0]   bus_rdata_o,
   input  logic [NUM_SRC-1:0] src_i,
   output logic               irq_o
);
   if (NUM_SRC < 1 || NUM_SRC > REG_W) begin : g_bad_num
      $error("NUM_SRC must lie in 1..32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must be at least 5");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_SRC-1:0] sync_src, pend, lvl_act;
   logic [NUM_SRC-1:0] enable, smode, ssens, w1c, force_set, cfg_clr;
   logic               osty, osens;

   intagg_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .async_i(src_i), .sync_o(sync_src));

   intagg_detect #(.NUM_SRC(NUM_SRC)) u_detect (
      .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_src),
      .smode_i(smode), .ssens_i(ssens), .w1c_i(w1c), .force_i(force_set),
      .cfg_clr_i(cfg_clr), .pend_o(pend), .lvl_act_o(lvl_act));

   intagg_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
      .wdata_i(bus_wdata_i), .pend_i(pend), .rdata_o(bus_rdata_o),
      .enable_o(enable), .smode_o(smode), .ssens_o(ssens), .w1c_o(w1c),
      .force_o(force_set), .cfg_clr_o(cfg_clr), .osty_o(osty), .osens_o(osens));

   intagg_outgen #(.NUM_SRC(NUM_SRC)) u_out (
      .clk_i(clk_i), .rst_ni(rst_ni), .pend_i(pend), .enable_i(enable),
      .osty_i(osty), .osens_i(osens), .irq_o(irq_o));
endmodule

// File: rtl/intagg_ctrl_chk.sv
module intagg_ctrl_chk #(
   parameter int NUM_SRC = 32,
   parameter int ADDR_W  = 5
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               wr,
   input logic [ADDR_W-1:0]  addr,
   input logic [31:0]        wdata,
   input logic [31:0]        rdata,
   input logic [NUM_SRC-1:0] pend,
   input logic [NUM_SRC-1:0] enable,
   input logic [NUM_SRC-1:0] smode,
   input logic [NUM_SRC-1:0] lvl_act,
   input logic               osty,
   input logic               osens,
   input logic               irq
);
   logic       in_rng;
   logic [2:0] word;
   logic [NUM_SRC-1:0] wb;

   assign in_rng = ((addr >> 5) == '0) && (addr[1:0] == 2'b00);
   assign word   = addr[4:2];
   assign wb     = wdata[NUM_SRC-1:0];

   // R6
   force_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && in_rng && word == 3'd6) |=> ((pend & $past(wb)) == $past(wb)));

   // R7
   cfg_change_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && in_rng && word == 3'd2) |=> ((pend & $past(wb ^ smode)) == '0));

   // R4
   level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr && in_rng && (word == 3'd2 || word == 3'd3))
      |=> (($past(lvl_act & ~smode) & ~pend) == '0));

   // R8
   out_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !osty |=> (irq == !($past(|(pend & enable)) ^ osens)));

   // R2
   force_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_rng && word == 3'd6) |-> (rdata == '0));
endmodule

bind intagg_ctrl intagg_ctrl_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .wr(bus_wr_i), .addr(bus_addr_i),
   .wdata(bus_wdata_i), .rdata(bus_rdata_o), .pend(pend), .enable(enable),
   .smode(smode), .lvl_act(lvl_act), .osty(osty), .osens(osens), .irq(irq_o));

// File: tb/intagg_ctrl_tb_top.sv
module intagg_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 32;
   localparam logic [4:0] A_EN = 5'h00, A_PD = 5'h04, A_SM = 5'h08, A_SS = 5'h0C,
                          A_OS = 5'h10, A_OP = 5'h14, A_FR = 5'h18, A_NO = 5'h1C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [4:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NS-1:0] src = '1;
   logic          irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   intagg_ctrl #(.NUM_SRC(NS), .ADDR_W(5), .SYNC_STAGES(2)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
      .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .src_i(src), .irq_o(irq));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   function automatic logic [31:0] exp_pend(input logic [31:0] o, input logic [31:0] n,
                                            input logic [31:0] m, input logic [31:0] p,
                                            input logic [31:0] f);
      logic [31:0] r;
      for (int b = 0; b < NS; b++) begin
         if (m[b]) r[b] = p[b] ? (!o[b] && n[b]) : (o[b] && !n[b]);
         else      r[b] = (p[b] ? o[b] : !o[b]) | (p[b] ? n[b] : !n[b]);
      end
      return r | f;
   endfunction

   function automatic logic exp_irq(input logic [31:0] pd, input logic [31:0] en, input logic pol);
      logic any;
      any = |(pd & en);
      return pol ? any : !any;
   endfunction

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, smv, spv, env, fv, oldv, newv;
      logic opv;
      void'($urandom(32'h5EED_0042));

      // R1 reset state, sampled while reset is held
      wait_n(2);
      rd(A_EN, d); check("R1 enable", d, 0);
      rd(A_PD, d); check("R1 pending", d, 0);
      rd(A_SM, d); check("R1 mode", d, 0);
      rd(A_OP, d); check("R1 out sense", d, 0);
      check("R1 irq idle", {31'b0, irq}, 1);
      rst_n = 1'b1;
      wait_n(4);

      // R11 start-up sequence with sources idle high (inactive for active-low level)
      wr(A_EN, 0); wr(A_OS, 0); wr(A_OP, 0); wr(A_PD, 32'hFFFF_FFFF);
      wait_n(1);
      rd(A_PD, d); check("R11 pending after init", d, 0);
      check("R11 irq inactive", {31'b0, irq}, 1);

      // R2 map readback
      wr(A_EN, 32'hA5A5_A5A5); rd(A_EN, d); check("R2 enable readback", d, 32'hA5A5_A5A5);
      wr(A_OS, 32'h3); rd(A_OS, d); check("R2 style bit0 only", d, 1);
      wr(A_OS, 0); wr(A_EN, 0);
      wr(A_NO, 32'hFFFF_FFFF); rd(A_NO, d); check("R2 unused offset", d, 0);

      // R3 edge: bit0 rising, bit1 falling
      wr(A_SM, 32'h3); wr(A_SS, 32'h1); wait_n(3); wr(A_PD, 32'h3);
      src[0] = 1'b0; wait_n(4);
      rd(A_PD, d); check("R3 wrong edge ignored", d, 0);
      src[0] = 1'b1; wait_n(2);
      rd(A_PD, d); check("R3 not yet after two edges", d, 0);
      wait_n(1);
      rd(A_PD, d); check("R3 rising sets on third edge", d, 32'h1);
      src[1] = 1'b0; wait_n(3);
      rd(A_PD, d); check("R3 falling edge", d, 32'h3);

      // R5 write-one-to-clear
      wr(A_PD, 0); rd(A_PD, d); check("R5 write zero keeps", d, 32'h3);
      wr(A_PD, 32'h1); rd(A_PD, d); check("R5 clear bit0", d, 32'h2);
      wr(A_PD, 32'h2); rd(A_PD, d); check("R5 clear bit1", d, 0);

      // R4 level, bit2 active high with source high
      wr(A_SS, 32'h5); wait_n(3);
      rd(A_PD, d); check("R4 level active sets", d, 32'h4);
      wr(A_PD, 32'h4); wait_n(1);
      rd(A_PD, d); check("R5 clear ignored while active", d, 32'h4);
      src[2] = 1'b0; wait_n(4);
      rd(A_PD, d); check("R4 latched after level drops", d, 32'h4);
      wr(A_PD, 32'h4); rd(A_PD, d); check("R4 cleared once inactive", d, 0);

      // R6 force on bit4 (idle level source)
      wr(A_FR, 32'h10); rd(A_PD, d); check("R6 force sets", d, 32'h10);
      rd(A_FR, d); check("R2 force reads zero", d, 0);

      // R7 trigger change clears changed bit only
      wr(A_FR, 32'h1); rd(A_PD, d); check("R6 force edge source", d, 32'h11);
      wr(A_SM, 32'h13); rd(A_PD, d); check("R7 changed bit cleared", d, 32'h1);

      // R8 / R10 level output
      wr(A_OP, 1); wr(A_EN, 32'h1); wait_n(1);
      check("R8 level output asserted", {31'b0, irq}, 1);
      wr(A_OP, 0); check("R10 active low", {31'b0, irq}, 0);
      wr(A_PD, 32'h1); wait_n(1);
      check("R8 output released", {31'b0, irq}, 1);

      // R9 pulse output
      wr(A_OP, 1); wr(A_OS, 1);
      wr(A_FR, 32'h1);
      check("R9 pulse not yet", {31'b0, irq}, 0);
      wait_n(1); check("R9 pulse high", {31'b0, irq}, 1);
      wait_n(1); check("R9 pulse one cycle", {31'b0, irq}, 0);
      wr(A_OS, 0); wr(A_EN, 0); wr(A_PD, 32'hFFFF_FFFF);

      // random rounds: R3 R4 R6 R8 R10
      for (int k = 0; k < 60; k++) begin
         smv = $urandom(); spv = $urandom(); env = $urandom(); opv = 1'($urandom());
         fv  = $urandom() & $urandom();
         oldv = src;
         wr(A_SM, smv); wr(A_SS, spv); wr(A_EN, env); wr(A_OP, {31'b0, opv});
         wait_n(3);
         wr(A_PD, 32'hFFFF_FFFF);
         wr(A_FR, fv);
         newv = $urandom();
         src = newv;
         wait_n(5);
         rd(A_PD, d);
         check("R3 R4 R6 random pending", d, exp_pend(oldv, newv, smv, spv, fv));
         check("R8 R10 random irq", {31'b0, irq},
               {31'b0, exp_irq(exp_pend(oldv, newv, smv, spv, fv), env, opv)});
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule